// File: doc/BRIEF.md
# Triggered Latency Pipeline and Serial Frame Readout

This block keeps a short history of binary hit data for a strip readout channel array. On every bunch-crossing clock it writes one 254-bit hit vector into a 256-entry circular memory. When a level-1 trigger arrives, it looks back a programmed number of crossings, fetches that crossing's hit vector, and queues it in a 32-entry event buffer. The buffer absorbs bursts of triggers that arrive closer together than one readout frame.

A serializer takes events from the buffer in arrival order and sends each one on a single data line as an unsparsified frame. Each frame is a 12-bit header followed by one bit for every channel. In the hit field, the bits of the two sensor layers alternate. Frames follow each other with no gap while events are waiting. The line rests at 0 when nothing is queued.

A fast reset returns all control state to its starting point without touching the stored hit history.

Top module: `trig_frame_readout`

## Requirements
- R1: After the synchronous reset `rst`, the outputs `sdata`, `buf_full` and `ovf_pending` are all 0.
- R2: A trigger sampled at a clock edge with `latency` = L, where 1 <= L <= 255, produces a frame. Its hit field carries the `hits` vector that was sampled L edges before that trigger edge.
- R3: A frame is sent most significant bit first. It starts with two bits of value 1, then the latency error bit, then the overflow bit, then an 8-bit address MSB first. The address equals (crossing count since the last reset − L) mod 256, where the crossing count at the trigger edge starts at 0 on the first edge after reset.
- R4: The 254 hit bits follow the header as pairs, for i = 0 to 126. The first bit of each pair is `hits[i]` (upper layer channel i) and the second is `hits[127+i]` (lower layer channel i).
- R5: A trigger taken with `latency` = 0 gives a frame whose latency error bit is 1 and whose hit field is all 0. For any other value the latency error bit is 0.
- R6: With the buffer empty and no frame in progress, the first header bit of a triggered event appears on `sdata` in the cycle after the second clock edge following the trigger edge. Queued frames follow each other with no idle cycle. `sdata` is 0 whenever no frame is being sent.
- R7: The buffer holds up to 32 events. `buf_full` is 1 exactly while 32 events wait to be sent, not counting the frame currently being shifted out.
- R8: A trigger whose event reaches the buffer, one edge after the trigger edge, while the buffer is full is discarded. This sets `ovf_pending`. The next frame started after that edge carries an overflow bit of 1, and `ovf_pending` then clears unless another event is discarded at the same edge.
- R9: `fast_rst` sampled high empties the buffer, aborts any frame so that `sdata` is 0 from the next cycle, clears `ovf_pending`, and restarts the crossing count at 0. The stored hit history is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_rst | input | 1 | Synchronous clear of pointers, buffer, serializer and flag |
| hits | input | 254 | Binary hits; [126:0] upper layer, [253:127] lower layer |
| trig | input | 1 | Level-1 trigger, one event per cycle high |
| latency | input | 8 | Look-back distance in crossings |
| sdata | output | 1 | Serial frame output, MSB first, idles at 0 |
| buf_full | output | 1 | Event buffer holds 32 waiting events |
| ovf_pending | output | 1 | A trigger was discarded and not yet reported in a frame |

## Verification
The bench aims at these corner cases:
- Look-back distances of 1 and 255, to catch an off-by-one in the ring arithmetic. Such an error would fetch the neighbouring crossing or the entry being written.
- A latency of 0. A design that mishandled it would send real hits or a clear error bit.
- A burst of 40 consecutive triggers. This exposes a buffer that accepts a 33rd event, loses the overflow mark, or reports it in the wrong frame.
- A fast reset in the middle of a frame. A faulty design would keep shifting or restart its addresses at the wrong place.
- Long random traffic with two adjacent triggers. This catches any idle gap or repeated bit between back-to-back frames.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  // Leading pattern of every frame
  localparam int SYNC_W = 2;
  localparam logic [SYNC_W-1:0] SYNC_CODE = 2'b11;
  // Latency error and overflow flags
  localparam int FLAG_W = 2;
endpackage

// File: rtl/lat_ring.sv
// Circular hit history. Written every crossing; a trigger reads the
// entry that lies lat entries behind the write pointer.
module lat_ring #(
  parameter int N_CH  = 254,
  parameter int DEPTH = 256,   // power of two, so pointer wrap is the modulo
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            clr,
  input  logic [N_CH-1:0] hits_in,
  input  logic            trig,
  input  logic [AW-1:0]   lat,
  output logic            ev_valid,
  output logic [N_CH-1:0] ev_hits,
  output logic [AW-1:0]   ev_addr,
  output logic            ev_laterr
);
  logic [N_CH-1:0] mem [DEPTH];
  logic [N_CH-1:0] rd_q;
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   raddr;

  assign raddr = wptr - lat;

  // Storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    mem[wptr] <= hits_in;
    rd_q      <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr      <= '0;
      ev_valid  <= 1'b0;
      ev_addr   <= '0;
      ev_laterr <= 1'b0;
    end else begin
      wptr      <= wptr + 1'b1;
      ev_valid  <= trig;
      ev_addr   <= raddr;
      ev_laterr <= (lat == '0);
    end
  end

  // A zero look-back would hit the entry under write: send no hits
  assign ev_hits = ev_laterr ? '0 : rd_q;
endmodule

// File: rtl/evt_fifo.sv
// Event buffer between trigger capture and serial readout.
module evt_fifo #(
  parameter int W     = 263,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_en, rd_en;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign wr_en = push && !full;
  assign rd_en = pop && !empty;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/frame_ser.sv
// Builds header plus layer-interleaved hit field and shifts it out MSB first.
module frame_ser
  import rdo_pkg::*;
#(
  parameter int N_CH = 254,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            avail,
  input  logic [N_CH-1:0] ev_hits,
  input  logic [AW-1:0]   ev_addr,
  input  logic            ev_laterr,
  input  logic            ovf_in,
  output logic            load,
  output logic            active,
  output logic            sdata
);
  localparam int HALF = N_CH / 2;
  localparam int HDR  = SYNC_W + FLAG_W + AW;
  localparam int FLEN = HDR + N_CH;
  localparam int CW   = $clog2(FLEN);

  logic [FLEN-1:0] shreg, frame;
  logic [CW-1:0]   cnt;
  logic            last;

  assign last = active && (cnt == CW'(FLEN - 1));
  assign load = (!active || last) && avail;

  always_comb begin
    frame = '0;
    frame[FLEN-1 -: HDR] = {SYNC_CODE, ev_laterr, ovf_in, ev_addr};
    for (int i = 0; i < HALF; i++) begin
      frame[N_CH-1-2*i] = ev_hits[i];
      frame[N_CH-2-2*i] = ev_hits[HALF+i];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      shreg  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= frame;
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      shreg  <= shreg << 1;
      cnt    <= last ? '0 : cnt + 1'b1;
      active <= !last;
    end
  end

  assign sdata = shreg[FLEN-1];
endmodule

// File: rtl/trig_frame_readout.sv
module trig_frame_readout #(
  parameter int N_CH       = 254,
  parameter int PIPE_DEPTH = 256,
  parameter int BUF_DEPTH  = 32,
  parameter int LAT_W      = $clog2(PIPE_DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fast_rst,
  input  logic [N_CH-1:0] hits,
  input  logic            trig,
  input  logic [LAT_W-1:0] latency,
  output logic            sdata,
  output logic            buf_full,
  output logic            ovf_pending
);
  localparam int EV_W = N_CH + LAT_W + 1;
  localparam int BAW  = $clog2(BUF_DEPTH);

  logic            ctl_clr;
  logic            st_valid, st_laterr;
  logic [N_CH-1:0] st_hits;
  logic [LAT_W-1:0] st_addr;
  logic [EV_W-1:0] fifo_out;
  logic            fifo_empty, fifo_full;
  logic [BAW:0]    fifo_count;
  logic            ser_load, ser_active;
  logic            drop;

  assign ctl_clr = rst || fast_rst;

  lat_ring #(.N_CH(N_CH), .DEPTH(PIPE_DEPTH), .AW(LAT_W)) u_ring (
    .clk(clk), .clr(ctl_clr), .hits_in(hits), .trig(trig), .lat(latency),
    .ev_valid(st_valid), .ev_hits(st_hits), .ev_addr(st_addr), .ev_laterr(st_laterr)
  );

  evt_fifo #(.W(EV_W), .DEPTH(BUF_DEPTH), .AW(BAW)) u_buf (
    .clk(clk), .clr(ctl_clr), .push(st_valid), .din({st_laterr, st_addr, st_hits}),
    .pop(ser_load), .dout(fifo_out), .empty(fifo_empty), .full(fifo_full),
    .count(fifo_count)
  );

  frame_ser #(.N_CH(N_CH), .AW(LAT_W)) u_ser (
    .clk(clk), .clr(ctl_clr), .avail(!fifo_empty),
    .ev_hits(fifo_out[N_CH-1:0]), .ev_addr(fifo_out[N_CH +: LAT_W]),
    .ev_laterr(fifo_out[EV_W-1]), .ovf_in(ovf_pending),
    .load(ser_load), .active(ser_active), .sdata(sdata)
  );

  assign drop = st_valid && fifo_full;

  always_ff @(posedge clk) begin
    if (ctl_clr)       ovf_pending <= 1'b0;
    else if (drop)     ovf_pending <= 1'b1;
    else if (ser_load) ovf_pending <= 1'b0;
  end

  assign buf_full = fifo_full;
endmodule

// File: rtl/readout_chk.sv
module readout_chk #(
  parameter int BUF_DEPTH = 32,
  parameter int CNT_W     = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             fast_rst,
  input logic             sdata,
  input logic             buf_full,
  input logic             ovf_pending,
  input logic             st_valid,
  input logic [CNT_W-1:0] fifo_count,
  input logic             ser_load,
  input logic             ser_active
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!sdata && !buf_full && !ovf_pending));

  // R9
  fast_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fast_rst) |-> (!sdata && !buf_full && !ovf_pending));

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst || fast_rst)
    (st_valid && buf_full) |=> ovf_pending);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst || fast_rst)
    (ser_load && !(st_valid && buf_full)) |=> !ovf_pending);

  // R7
  depth_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(BUF_DEPTH));

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (rst || fast_rst)
    ser_load |=> sdata);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_active |-> !sdata);
endmodule

bind trig_frame_readout readout_chk #(.BUF_DEPTH(BUF_DEPTH), .CNT_W($clog2(BUF_DEPTH) + 1)) u_chk (
  .clk(clk), .rst(rst), .fast_rst(fast_rst), .sdata(sdata), .buf_full(buf_full),
  .ovf_pending(ovf_pending), .st_valid(st_valid), .fifo_count(fifo_count),
  .ser_load(ser_load), .ser_active(ser_active)
);

// File: tb/tb_trig_frame_readout.sv
module tb_trig_frame_readout;
  localparam int NC   = 254;
  localparam int HF   = NC / 2;
  localparam int FL   = 12 + NC;
  localparam int BDEP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fast_rst = 1'b0;
  logic [NC-1:0] hits = '0;
  logic          trig = 1'b0;
  logic [7:0]    latency = 8'd0;
  logic          sdata, buf_full, ovf_pending;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  trig_frame_readout dut (
    .clk(clk), .rst(rst), .fast_rst(fast_rst), .hits(hits), .trig(trig),
    .latency(latency), .sdata(sdata), .buf_full(buf_full), .ovf_pending(ovf_pending)
  );

  always #4 clk = ~clk;

  // Reference state, built from the requirements
  logic [NC-1:0] hist [256];
  int            m_wptr = 0;
  bit            st_v = 0;
  logic [NC-1:0] st_h;
  int            st_a = 0;
  bit            st_le = 0;
  logic [FL-1:0] q[$];
  bit            m_ovf = 0;
  logic [FL-1:0] m_sh = '0;
  int            m_cnt = 0;
  bit            m_act = 0;
  bit            last_r = 1, last_fr = 0;

  function automatic logic [FL-1:0] build(logic [NC-1:0] h, int a, bit le);
    logic [FL-1:0] f;
    f = '0;
    f[FL-1] = 1'b1;
    f[FL-2] = 1'b1;
    f[FL-3] = le;
    f[FL-5 -: 8] = a[7:0];
    for (int i = 0; i < HF; i++) begin
      f[NC-1-2*i] = le ? 1'b0 : h[i];
      f[NC-2-2*i] = le ? 1'b0 : h[HF+i];
    end
    return f;
  endfunction

  function automatic logic [NC-1:0] rand_hits();
    logic [255:0] t;
    for (int w = 0; w < 8; w++) t[w*32 +: 32] = $urandom;
    return t[NC-1:0];
  endfunction

  function automatic string pos_tag(bit act, int c);
    if (!act)   return "R6";
    if (c < 2)  return "R3";
    if (c == 2) return "R5";
    if (c == 3) return "R8";
    if (c < 12) return "R3";
    return "R2,R4,R5";
  endfunction

  task automatic model_edge(bit r, bit fr, bit tg, logic [7:0] L, logic [NC-1:0] h);
    int sz;
    bit last, ld, drop, psh;
    logic [FL-1:0] f;
    sz   = q.size();
    last = m_act && (m_cnt == FL - 1);
    ld   = (!m_act || last) && (sz > 0);
    drop = st_v && (sz == BDEP);
    psh  = st_v && (sz < BDEP);
    if (r || fr) begin
      q.delete();
      m_ovf = 0; m_sh = '0; m_cnt = 0; m_act = 0; st_v = 0; st_a = 0; st_le = 0;
    end else begin
      if (ld) begin
        f = q.pop_front();
        f[FL-4] = m_ovf;
        m_sh = f; m_cnt = 0; m_act = 1;
      end else if (m_act) begin
        m_sh  = m_sh << 1;
        m_cnt = last ? 0 : m_cnt + 1;
        m_act = !last;
      end
      if (psh) q.push_back(build(st_h, st_a, st_le));
      if (drop) m_ovf = 1;
      else if (ld) m_ovf = 0;
      st_v  = tg;
      st_a  = (m_wptr - int'(L)) & 255;
      st_le = (L == 8'd0);
      st_h  = hist[st_a];
    end
    hist[m_wptr] = h;
    m_wptr = (r || fr) ? 0 : (m_wptr + 1) & 255;
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One crossing: drive at the falling edge, let the rising edge pass, compare
  task automatic step(bit r, bit fr, bit tg, logic [7:0] L);
    logic [NC-1:0] h;
    string t_s, t_f, t_o;
    h = rand_hits();
    rst = r; fast_rst = fr; trig = tg; latency = L; hits = h;
    model_edge(r, fr, tg, L, h);
    last_r = r; last_fr = fr;
    @(negedge clk);
    t_s = r ? "R1" : (fr ? "R9" : pos_tag(m_act, m_cnt));
    t_f = r ? "R1" : (fr ? "R9" : "R7");
    t_o = r ? "R1" : (fr ? "R9" : "R8");
    chk(sdata === m_sh[FL-1], t_s, "sdata", int'(sdata), int'(m_sh[FL-1]));
    chk(buf_full === (q.size() == BDEP), t_f, "buf_full", int'(buf_full), int'(q.size() == BDEP));
    chk(ovf_pending === m_ovf, t_o, "ovf_pending", int'(ovf_pending), int'(m_ovf));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'd7);
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) hist[i] = '0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1, 0, 0, 8'd0);
    idle(300);
    // R2 R3: nominal, minimum and maximum look-back
    step(0, 0, 1, 8'd5);   idle(280);
    step(0, 0, 1, 8'd1);   idle(280);
    step(0, 0, 1, 8'd255); idle(280);
    // R5: zero look-back
    step(0, 0, 1, 8'd0);   idle(280);
    // R6: adjacent triggers give back-to-back frames
    step(0, 0, 1, 8'd10);
    step(0, 0, 1, 8'd11);  idle(560);
    // R7 R8: burst beyond buffer depth
    for (int i = 0; i < 40; i++) step(0, 0, 1, 8'($urandom_range(1, 255)));
    idle(34 * FL + 50);
    // R9: fast reset in the middle of a frame
    step(0, 0, 1, 8'd40);
    idle(100);
    step(0, 1, 0, 8'd0);
    idle(300);
    step(0, 0, 1, 8'd20);  idle(280);
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      bit tg;
      tg = ($urandom_range(0, 199) == 0);
      step(0, 0, tg, 8'($urandom_range(0, 255)));
    end
    idle(3 * FL);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule